// File: doc/BRIEF.md
# Host-DSP Doorbell Register Block

This block carries short two-word messages between a host processor and a DSP in both directions. Each side has its own simple register port: a select, a write strobe, a 3-bit word address, write data and combinational read data. On the host-to-DSP path, the host first loads an extension word. It then writes the primary word with bit 31 set, and that write rings the doorbell. The DSP reads both words. When it has consumed them, it acknowledges with one write. That write drops the pending flag and raises a completion flag, which the host clears by writing a one to it.

The DSP-to-host path is the mirror image. The DSP posts an extension word and a primary word. Bit 30 of the primary word tells the host whether the message answers an earlier request or is an unsolicited notification. The host accepts the message by writing a one to the pending flag, which silences the interrupt. It reports that handling is finished by writing zero to the flag in the acknowledge register, and this frees the path for the next post.

A control register holds separate enables for the incoming-message interrupt and the completion interrupt. A single level interrupt line goes to the host. It is registered and changes on the same edge as the flags that drive it.

Top module: `ipc_doorbell`

## Requirements
- R1: After reset every readable register on both ports reads zero and host_irq is low.
- R2: A host write to host address 0 with bit 31 set, while the request is idle, stores bits 30:0 and sets the request pending flag (bit 31). Host address 0 and DSP address 0 both read {pending, message}. A write with bit 31 clear has no effect.
- R3: A host write to address 0 with bit 31 set while the request is still pending leaves the stored message unchanged and sets a sticky overflow flag at bit 0 of host address 7. Writing a one to that bit clears the flag.
- R4: A DSP write to DSP address 2 with bit 31 set, while the request is pending, clears the pending flag and sets the completion flag (bit 31 of host address 2 and of DSP address 2) in the same cycle. When no request is pending, the write has no effect.
- R5: A host write to address 2 with bit 31 set clears the completion flag. With bit 31 clear, the write has no effect.
- R6: A DSP write to DSP address 3 with bit 31 set, while the DSP-to-host path is idle, stores bits 30:0 and sets both the target pending flag (bit 31 of host/DSP address 3) and the target handling flag (bit 31 of host/DSP address 5). The direction bit 30 is delivered unchanged.
- R7: A host write to address 3 with bit 31 set clears the target pending flag and leaves the handling flag untouched.
- R8: A host write to address 5 with bit 31 clear clears the handling flag. With bit 31 set, the write has no effect. A DSP post is ignored while either target flag is set.
- R9: Host address 6 holds the incoming-message enable at bit 0 and the completion enable at bit 1. host_irq equals (target pending AND bit 0) OR (completion AND bit 1), and it updates on the same edge as those flags.
- R10: Extension words (host address 1 for requests, DSP address 4 for targets) accept writes only while their path is idle. Otherwise they keep their value. DSP address 1 and host address 4 read these words back, and unused DSP addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 1 | Host port select |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 3 | Host word address |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data |
| d_sel | input | 1 | DSP port select |
| d_wr | input | 1 | DSP write strobe |
| d_addr | input | 3 | DSP word address |
| d_wdata | input | DW | DSP write data |
| d_rdata | output | DW | DSP read data |
| host_irq | output | 1 | Level interrupt to host |

## Verification
Some states need a particular order of operations from both ports. Overflow needs a second ring while the first request is still pending. A blocked DSP post needs a target whose pending flag has been accepted while its handling flag is still up. Pure random writes reach these orders only rarely. The stimulus therefore mixes directed sequences with random operations. The random draws favour the few addresses and bit-31 values that move the handshakes forward. After every operation a reference model predicts every register on both ports and the interrupt line.

// File: rtl/ipc_db_pkg.sv
package ipc_db_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    H_REQ     = 3'd0,
    H_REQ_EXT = 3'd1,
    H_REQ_ACK = 3'd2,
    H_TGT     = 3'd3,
    H_TGT_EXT = 3'd4,
    H_TGT_ACK = 3'd5,
    H_CTL     = 3'd6,
    H_STAT    = 3'd7
  } host_reg_e;

  typedef enum logic [REG_AW-1:0] {
    D_REQ     = 3'd0,
    D_REQ_EXT = 3'd1,
    D_REQ_ACK = 3'd2,
    D_TGT     = 3'd3,
    D_TGT_EXT = 3'd4,
    D_TGT_ACK = 3'd5
  } dsp_reg_e;

  localparam int BUSY_IE_BIT = 0;
  localparam int DONE_IE_BIT = 1;
  localparam int OVF_BIT     = 0;
endpackage

// File: rtl/ipc_db_req_chan.sv
module ipc_db_req_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ring_wr,
  input  logic [DW-1:0] ring_data,
  input  logic          ext_wr,
  input  logic [DW-1:0] ext_data,
  input  logic          ack_wr,
  input  logic          done_clr,
  input  logic          ovf_clr,
  output logic          busy,
  output logic [DW-2:0] msg,
  output logic [DW-1:0] ext,
  output logic          done,
  output logic          done_nx,
  output logic          ovf
);
  localparam int FLAG = DW - 1;

  logic          busy_q, busy_d;
  logic [DW-2:0] msg_q, msg_d;
  logic [DW-1:0] ext_q, ext_d;
  logic          done_q, done_d;
  logic          ovf_q, ovf_d;
  logic          en;

  assign en = ring_wr | ext_wr | ack_wr | done_clr | ovf_clr;

  always_comb begin
    busy_d = busy_q;
    msg_d  = msg_q;
    ext_d  = ext_q;
    done_d = done_q;
    ovf_d  = ovf_q;
    if (ovf_clr) ovf_d = 1'b0;
    if (ring_wr && ring_data[FLAG]) begin
      if (busy_q) begin
        ovf_d = 1'b1;
      end else begin
        busy_d = 1'b1;
        msg_d  = ring_data[DW-2:0];
      end
    end
    if (ext_wr && !busy_q) ext_d = ext_data;
    if (done_clr) done_d = 1'b0;
    if (ack_wr && busy_q) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      msg_q  <= '0;
      ext_q  <= '0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (en) begin
      busy_q <= busy_d;
      msg_q  <= msg_d;
      ext_q  <= ext_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
    end
  end

  assign busy    = busy_q;
  assign msg     = msg_q;
  assign ext     = ext_q;
  assign done    = done_q;
  assign done_nx = en ? done_d : done_q;
  assign ovf     = ovf_q;
endmodule

// File: rtl/ipc_db_tgt_chan.sv
module ipc_db_tgt_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          post_wr,
  input  logic [DW-1:0] post_data,
  input  logic          ext_wr,
  input  logic [DW-1:0] ext_data,
  input  logic          busy_clr,
  input  logic          hand_clr,
  output logic          busy,
  output logic          busy_nx,
  output logic [DW-2:0] msg,
  output logic [DW-1:0] ext,
  output logic          hand
);
  localparam int FLAG = DW - 1;

  logic          busy_q, busy_d;
  logic          hand_q, hand_d;
  logic [DW-2:0] msg_q, msg_d;
  logic [DW-1:0] ext_q, ext_d;
  logic          idle;
  logic          en;

  assign idle = !busy_q && !hand_q;
  assign en   = post_wr | ext_wr | busy_clr | hand_clr;

  always_comb begin
    busy_d = busy_q;
    hand_d = hand_q;
    msg_d  = msg_q;
    ext_d  = ext_q;
    if (post_wr && post_data[FLAG] && idle) begin
      busy_d = 1'b1;
      hand_d = 1'b1;
      msg_d  = post_data[DW-2:0];
    end
    if (ext_wr && idle) ext_d = ext_data;
    if (busy_clr) busy_d = 1'b0;
    if (hand_clr) hand_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hand_q <= 1'b0;
      msg_q  <= '0;
      ext_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      hand_q <= hand_d;
      msg_q  <= msg_d;
      ext_q  <= ext_d;
    end
  end

  assign busy    = busy_q;
  assign busy_nx = en ? busy_d : busy_q;
  assign msg     = msg_q;
  assign ext     = ext_q;
  assign hand    = hand_q;
endmodule

// File: rtl/ipc_db_irq_ctl.sv
module ipc_db_irq_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_data,
  input  logic       busy_nx,
  input  logic       done_nx,
  output logic       busy_ie,
  output logic       done_ie,
  output logic       irq
);
  import ipc_db_pkg::*;

  logic bie_q, bie_d, die_q, die_d, irq_q, irq_d;

  always_comb begin
    bie_d = bie_q;
    die_d = die_q;
    if (ctl_wr) begin
      bie_d = ctl_data[BUSY_IE_BIT];
      die_d = ctl_data[DONE_IE_BIT];
    end
    irq_d = (busy_nx & bie_d) | (done_nx & die_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bie_q <= 1'b0;
      die_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        bie_q <= bie_d;
        die_q <= die_d;
      end
      irq_q <= irq_d;
    end
  end

  assign busy_ie = bie_q;
  assign done_ie = die_q;
  assign irq     = irq_q;
endmodule

// File: rtl/ipc_doorbell.sv
module ipc_doorbell #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_sel,
  input  logic          h_wr,
  input  logic [2:0]    h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          d_sel,
  input  logic          d_wr,
  input  logic [2:0]    d_addr,
  input  logic [DW-1:0] d_wdata,
  output logic [DW-1:0] d_rdata,
  output logic          host_irq
);
  import ipc_db_pkg::*;

  localparam int FLAG = DW - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic h_we, d_we;
  assign h_we = h_sel & h_wr;
  assign d_we = d_sel & d_wr;

  logic          req_busy, req_done, req_done_nx, req_ovf;
  logic [DW-2:0] req_msg;
  logic [DW-1:0] req_ext;
  logic          tgt_busy, tgt_busy_nx, tgt_hand;
  logic [DW-2:0] tgt_msg;
  logic [DW-1:0] tgt_ext;
  logic          irq_bie, irq_die;

  ipc_db_req_chan #(.DW(DW)) u_req (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ring_wr   (h_we && h_addr == H_REQ),
    .ring_data (h_wdata),
    .ext_wr    (h_we && h_addr == H_REQ_EXT),
    .ext_data  (h_wdata),
    .ack_wr    (d_we && d_addr == D_REQ_ACK && d_wdata[FLAG]),
    .done_clr  (h_we && h_addr == H_REQ_ACK && h_wdata[FLAG]),
    .ovf_clr   (h_we && h_addr == H_STAT && h_wdata[OVF_BIT]),
    .busy      (req_busy),
    .msg       (req_msg),
    .ext       (req_ext),
    .done      (req_done),
    .done_nx   (req_done_nx),
    .ovf       (req_ovf)
  );

  ipc_db_tgt_chan #(.DW(DW)) u_tgt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .post_wr   (d_we && d_addr == D_TGT),
    .post_data (d_wdata),
    .ext_wr    (d_we && d_addr == D_TGT_EXT),
    .ext_data  (d_wdata),
    .busy_clr  (h_we && h_addr == H_TGT && h_wdata[FLAG]),
    .hand_clr  (h_we && h_addr == H_TGT_ACK && !h_wdata[FLAG]),
    .busy      (tgt_busy),
    .busy_nx   (tgt_busy_nx),
    .msg       (tgt_msg),
    .ext       (tgt_ext),
    .hand      (tgt_hand)
  );

  ipc_db_irq_ctl u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ctl_wr   (h_we && h_addr == H_CTL),
    .ctl_data (h_wdata[1:0]),
    .busy_nx  (tgt_busy_nx),
    .done_nx  (req_done_nx),
    .busy_ie  (irq_bie),
    .done_ie  (irq_die),
    .irq      (host_irq)
  );

  logic [DW-1:0] req_word, tgt_word, done_word, hand_word;
  assign req_word  = {req_busy, req_msg};
  assign tgt_word  = {tgt_busy, tgt_msg};
  assign done_word = {req_done, {(DW-1){1'b0}}};
  assign hand_word = {tgt_hand, {(DW-1){1'b0}}};

  always_comb begin
    h_rdata = '0;
    case (h_addr)
      H_REQ:     h_rdata = req_word;
      H_REQ_EXT: h_rdata = req_ext;
      H_REQ_ACK: h_rdata = done_word;
      H_TGT:     h_rdata = tgt_word;
      H_TGT_EXT: h_rdata = tgt_ext;
      H_TGT_ACK: h_rdata = hand_word;
      H_CTL: begin
        h_rdata[BUSY_IE_BIT] = irq_bie;
        h_rdata[DONE_IE_BIT] = irq_die;
      end
      H_STAT:    h_rdata[OVF_BIT] = req_ovf;
      default:   h_rdata = '0;
    endcase
  end

  always_comb begin
    d_rdata = '0;
    case (d_addr)
      D_REQ:     d_rdata = req_word;
      D_REQ_EXT: d_rdata = req_ext;
      D_REQ_ACK: d_rdata = done_word;
      D_TGT:     d_rdata = tgt_word;
      D_TGT_EXT: d_rdata = tgt_ext;
      D_TGT_ACK: d_rdata = hand_word;
      default:   d_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ipc_doorbell_chk.sv
module ipc_doorbell_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_sel,
  input logic          h_wr,
  input logic [2:0]    h_addr,
  input logic [DW-1:0] h_wdata,
  input logic          d_sel,
  input logic          d_wr,
  input logic [2:0]    d_addr,
  input logic [DW-1:0] d_wdata,
  input logic          req_busy,
  input logic [DW-2:0] req_msg,
  input logic          req_done,
  input logic          req_ovf,
  input logic          tgt_busy,
  input logic          tgt_hand,
  input logic          irq_bie,
  input logic          irq_die,
  input logic          host_irq
);
  logic h_ring, d_ack, h_tclr, d_post;
  assign h_ring = h_sel && h_wr && h_addr == 3'd0 && h_wdata[DW-1];
  assign d_ack  = d_sel && d_wr && d_addr == 3'd2 && d_wdata[DW-1];
  assign h_tclr = h_sel && h_wr && h_addr == 3'd3 && h_wdata[DW-1];
  assign d_post = d_sel && d_wr && d_addr == 3'd3 && d_wdata[DW-1];

  assert_ring_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ring && !req_busy && !d_ack) |=> req_busy);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ring && req_busy && !d_ack) |=> (req_ovf && $stable(req_msg)));

  assert_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (d_ack && req_busy) |=> (!req_busy && req_done));

  assert_tgt_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    h_tclr |=> !tgt_busy);

  assert_post_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (d_post && tgt_hand && !h_tclr) |=> $stable(tgt_busy));

  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == ((tgt_busy && irq_bie) || (req_done && irq_die)));
endmodule

bind ipc_doorbell ipc_doorbell_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .h_sel    (h_sel),
  .h_wr     (h_wr),
  .h_addr   (h_addr),
  .h_wdata  (h_wdata),
  .d_sel    (d_sel),
  .d_wr     (d_wr),
  .d_addr   (d_addr),
  .d_wdata  (d_wdata),
  .req_busy (req_busy),
  .req_msg  (req_msg),
  .req_done (req_done),
  .req_ovf  (req_ovf),
  .tgt_busy (tgt_busy),
  .tgt_hand (tgt_hand),
  .irq_bie  (irq_bie),
  .irq_die  (irq_die),
  .host_irq (host_irq)
);

// File: tb/ipc_doorbell_tb.sv
`timescale 1ns/100ps
module ipc_doorbell_tb;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          h_sel, h_wr, d_sel, d_wr;
  logic [2:0]    h_addr, d_addr;
  logic [DW-1:0] h_wdata, d_wdata, h_rdata, d_rdata;
  logic          host_irq;

  always #2 clk = ~clk;

  ipc_doorbell #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .d_sel(d_sel), .d_wr(d_wr), .d_addr(d_addr), .d_wdata(d_wdata), .d_rdata(d_rdata),
    .host_irq(host_irq)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // reference model
  bit          m_rbusy, m_rdone, m_ovf, m_tbusy, m_thand, m_bie, m_die;
  logic [30:0] m_rmsg, m_tmsg;
  logic [31:0] m_rext, m_text;

  function automatic logic [31:0] exp_host(input int a);
    case (a)
      0: return {m_rbusy, m_rmsg};
      1: return m_rext;
      2: return {m_rdone, 31'b0};
      3: return {m_tbusy, m_tmsg};
      4: return m_text;
      5: return {m_thand, 31'b0};
      6: return {30'b0, m_die, m_bie};
      default: return {31'b0, m_ovf};
    endcase
  endfunction

  function automatic logic [31:0] exp_dsp(input int a);
    case (a)
      0: return {m_rbusy, m_rmsg};
      1: return m_rext;
      2: return {m_rdone, 31'b0};
      3: return {m_tbusy, m_tmsg};
      4: return m_text;
      5: return {m_thand, 31'b0};
      default: return 32'b0;
    endcase
  endfunction

  function automatic bit exp_irq();
    return (m_tbusy & m_bie) | (m_rdone & m_die);
  endfunction

  task automatic model_host(input int a, input logic [31:0] w);
    case (a)
      0: if (w[31]) begin
           if (m_rbusy) m_ovf = 1;
           else begin m_rbusy = 1; m_rmsg = w[30:0]; end
         end
      1: if (!m_rbusy) m_rext = w;
      2: if (w[31]) m_rdone = 0;
      3: if (w[31]) m_tbusy = 0;
      5: if (!w[31]) m_thand = 0;
      6: begin m_bie = w[0]; m_die = w[1]; end
      7: if (w[0]) m_ovf = 0;
      default: ;
    endcase
  endtask

  task automatic model_dsp(input int a, input logic [31:0] w);
    case (a)
      2: if (w[31] && m_rbusy) begin m_rbusy = 0; m_rdone = 1; end
      3: if (w[31] && !m_tbusy && !m_thand) begin
           m_tbusy = 1; m_thand = 1; m_tmsg = w[30:0];
         end
      4: if (!m_tbusy && !m_thand) m_text = w;
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      h_sel = 1; h_wr = 0; h_addr = 3'(a);
      d_sel = 1; d_wr = 0; d_addr = 3'(a);
      #1;
      check(tag, $sformatf("host reg %0d", a), h_rdata, exp_host(a));
      check(tag, $sformatf("dsp reg %0d", a), d_rdata, exp_dsp(a));
    end
    check("R9", "host_irq", {31'b0, host_irq}, {31'b0, exp_irq()});
    h_sel = 0; d_sel = 0;
  endtask

  task automatic host_write(input int a, input logic [31:0] w);
    @(negedge clk);
    h_sel = 1; h_wr = 1; h_addr = 3'(a); h_wdata = w;
    @(negedge clk);
    h_sel = 0; h_wr = 0;
    model_host(a, w);
  endtask

  task automatic dsp_write(input int a, input logic [31:0] w);
    @(negedge clk);
    d_sel = 1; d_wr = 1; d_addr = 3'(a); d_wdata = w;
    @(negedge clk);
    d_sel = 0; d_wr = 0;
    model_dsp(a, w);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1d0b_e11;
    void'($urandom(seed));
    h_sel = 0; h_wr = 0; h_addr = 0; h_wdata = 0;
    d_sel = 0; d_wr = 0; d_addr = 0; d_wdata = 0;
    {m_rbusy, m_rdone, m_ovf, m_tbusy, m_thand, m_bie, m_die} = '0;
    m_rmsg = '0; m_tmsg = '0; m_rext = '0; m_text = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    check_all("R1");

    // directed: request path with interrupt enables
    host_write(6, 32'h3);                 check_all("R9");
    host_write(0, 32'h1234_5678);         check_all("R2");   // bit31 clear: no effect
    host_write(1, 32'hCAFE_0001);         check_all("R10");
    host_write(0, 32'h8000_00AB);         check_all("R2");
    host_write(1, 32'hDEAD_0000);         check_all("R10");  // ext locked while pending
    host_write(0, 32'h8000_00CD);         check_all("R3");   // overflow
    host_write(7, 32'h1);                 check_all("R3");
    dsp_write(2, 32'h8000_0000);          check_all("R4");
    dsp_write(2, 32'h8000_0000);          check_all("R4");   // not pending: no effect
    host_write(2, 32'h0);                 check_all("R5");
    host_write(2, 32'h8000_0000);         check_all("R5");

    // directed: target path, reply then notification
    dsp_write(4, 32'h0BAD_F00D);          check_all("R10");
    dsp_write(3, 32'hC000_0011);          check_all("R6");   // direction bit set
    dsp_write(3, 32'h8000_0022);          check_all("R8");   // blocked
    host_write(3, 32'h8000_0000);         check_all("R7");
    dsp_write(3, 32'h8000_0033);          check_all("R8");   // still blocked by handling flag
    dsp_write(4, 32'h1111_1111);          check_all("R10");
    host_write(5, 32'h8000_0000);         check_all("R8");   // bit31 set: no effect
    host_write(5, 32'h0);                 check_all("R8");
    dsp_write(3, 32'h8000_0044);          check_all("R6");   // notification
    host_write(6, 32'h1);                 check_all("R9");
    host_write(3, 32'h8000_0000);         check_all("R7");

    // random mix
    for (int i = 0; i < 500; i++) begin
      int side, a, pick;
      logic [31:0] w;
      side = $urandom_range(0, 1);
      w = $urandom();
      if ($urandom_range(0, 3) != 0) w[31] = 1'b1;
      if (side == 0) begin
        pick = $urandom_range(0, 9);
        a = (pick < 8) ? pick : ((pick == 8) ? 5 : 0);
        if (a == 5) w[31] = $urandom_range(0, 1);
        host_write(a, w);
        check_all("R2");
      end else begin
        pick = $urandom_range(0, 7);
        a = (pick < 3) ? 2 : ((pick < 6) ? 3 : pick - 2);
        dsp_write(a, w);
        check_all("R6");
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule